// File: doc/BRIEF.md
# DMA Channel Event Flag and Interrupt Unit

This block holds the event status of a set of DMA channels and turns it into one interrupt line per channel. Each channel engine reports three kinds of event by single-cycle pulses: half of the buffer moved, the whole buffer moved, and a transfer error. Every pulse latches a sticky flag. Software can poll these flags through a read-only status word, or it can enable per-event interrupts. The enabled flags of a channel are ORed into that channel's request line.

Flags are never cleared by a read or by a write to the status word. The only way to clear them is a separate clear register, where each 1 bit clears the matching flag. Each channel also has a summary bit. That bit reads as the OR of its three flags, and a 1 written to its clear position clears all three flags at once. The register port is a plain strobe interface with a one-bit select: select 0 is the status word and select 1 is the clear register.

Top module: `dma_evt_flags`

## Requirements
- R1: An event pulse on a channel sets the matching flag at the next clock edge, whether or not that event's interrupt is enabled.
- R2: Channel c occupies bits 4c+3..4c of the status word, as follows: bit 4c is half-done, bit 4c+1 is complete, bit 4c+2 is error, and bit 4c+3 is the summary bit, which equals the OR of the other three.
- R3: A write with select 0 (status word) changes no flag.
- R4: A write with select 1 clears each flag whose clear bit (same position as in the status word) is 1. Flags whose clear bit is 0 keep their value.
- R5: A 1 in clear bit 4c+3 clears all three flags of channel c.
- R6: If an event pulse and a clear of the same flag occur in one cycle, the flag is set afterwards.
- R7: irq[c] is a level signal. It is high exactly while at least one flag of channel c is set and has its enable high. Dropping the enable removes the request without clearing the flag.
- R8: A read strobe loads reg_rdata at the next edge. With select 0 it loads the status word, and with select 1 it loads zero. Between reads, reg_rdata holds its value.
- R9: After reset, all flags, all irq lines and reg_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_half | input | NCH | Half-transfer event pulses, one per channel |
| evt_done | input | NCH | Transfer-complete event pulses |
| evt_err | input | NCH | Transfer-error event pulses |
| en_half | input | NCH | Interrupt enables for half-transfer |
| en_done | input | NCH | Interrupt enables for transfer-complete |
| en_err | input | NCH | Interrupt enables for transfer-error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 clear |
| reg_wdata | input | 4*NCH | Write data |
| reg_rdata | output | 4*NCH | Registered read data |
| irq | output | NCH | Per-channel interrupt request |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a new event on the same flag. The bench drives the event vector and the clear write together on one falling edge, so both are sampled at the same rising edge. It then reads the status back to confirm the event won. Writes to the status word are issued while flags are set, to show they change nothing. Enables are toggled while flags stay set, to separate the level-sensitive request from the sticky flag.

// File: rtl/dma_evt_flags.sv
module dma_evt_flags #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   evt_half,
  input  logic [NCH-1:0]   evt_done,
  input  logic [NCH-1:0]   evt_err,
  input  logic [NCH-1:0]   en_half,
  input  logic [NCH-1:0]   en_done,
  input  logic [NCH-1:0]   en_err,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_sel,
  input  logic [4*NCH-1:0] reg_wdata,
  output logic [4*NCH-1:0] reg_rdata,
  output logic [NCH-1:0]   irq
);
  localparam int W = 4 * NCH;

  logic [NCH-1:0] f_half, f_done, f_err;
  logic [NCH-1:0] clr_half, clr_done, clr_err;
  logic [W-1:0]   status;
  logic           clr_wr;

  assign clr_wr = reg_wr & reg_sel;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign clr_half[c] = clr_wr & (reg_wdata[4*c]   | reg_wdata[4*c+3]);
    assign clr_done[c] = clr_wr & (reg_wdata[4*c+1] | reg_wdata[4*c+3]);
    assign clr_err[c]  = clr_wr & (reg_wdata[4*c+2] | reg_wdata[4*c+3]);
    assign status[4*c+:4] = {f_half[c] | f_done[c] | f_err[c], f_err[c], f_done[c], f_half[c]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_half <= '0;
      f_done <= '0;
      f_err  <= '0;
    end else begin
      f_half <= (f_half & ~clr_half) | evt_half;
      f_done <= (f_done & ~clr_done) | evt_done;
      f_err  <= (f_err  & ~clr_err)  | evt_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= reg_sel ? '0 : status;
  end

  assign irq = (f_half & en_half) | (f_done & en_done) | (f_err & en_err);
endmodule

// File: rtl/dma_evt_flags_chk.sv
module dma_evt_flags_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   evt_half,
  input logic [NCH-1:0]   evt_done,
  input logic [NCH-1:0]   evt_err,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [4*NCH-1:0] reg_wdata,
  input logic [NCH-1:0]   f_half,
  input logic [NCH-1:0]   f_done,
  input logic [NCH-1:0]   f_err,
  input logic [NCH-1:0]   irq
);
  logic [NCH-1:0] m_half, m_done, m_err;
  for (genvar c = 0; c < NCH; c++) begin : g_m
    assign m_half[c] = reg_wr & reg_sel & (reg_wdata[4*c]   | reg_wdata[4*c+3]);
    assign m_done[c] = reg_wr & reg_sel & (reg_wdata[4*c+1] | reg_wdata[4*c+3]);
    assign m_err[c]  = reg_wr & reg_sel & (reg_wdata[4*c+2] | reg_wdata[4*c+3]);
  end

  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((f_half & $past(evt_half)) == $past(evt_half)) &&
              ((f_done & $past(evt_done)) == $past(evt_done)) &&
              ((f_err  & $past(evt_err))  == $past(evt_err))));

  assert_rise_needs_evt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((f_half & ~$past(f_half) & ~$past(evt_half)) == '0) &&
              ((f_err  & ~$past(f_err)  & ~$past(evt_err))  == '0)));

  assert_status_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> (((~f_half & $past(f_half)) == '0) &&
                              ((~f_done & $past(f_done)) == '0) &&
                              ((~f_err  & $past(f_err))  == '0)));

  assert_fall_needs_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~f_half & $past(f_half) & ~$past(m_half)) == '0) &&
              ((~f_done & $past(f_done) & ~$past(m_done)) == '0) &&
              ((~f_err  & $past(f_err)  & ~$past(m_err))  == '0)));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(f_half | f_done | f_err)) == '0);
endmodule

bind dma_evt_flags dma_evt_flags_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .f_half(f_half), .f_done(f_done), .f_err(f_err), .irq(irq)
);

// File: tb/sim_dma_evt_flags.sv
`timescale 1ns/1ps
module sim_dma_evt_flags;
  localparam int NCH = 4;
  localparam int W = 4 * NCH;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] evt_half = 0, evt_done = 0, evt_err = 0;
  logic [NCH-1:0] en_half = 0, en_done = 0, en_err = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [W-1:0] reg_wdata = 0;
  logic [W-1:0] reg_rdata;
  logic [NCH-1:0] irq;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [NCH-1:0] mh = 0, md = 0, me = 0;

  always #2 clk = ~clk;

  dma_evt_flags #(.NCH(NCH)) u0 (.*);

  function automatic logic [W-1:0] model_status();
    logic [W-1:0] s = '0;
    for (int c = 0; c < NCH; c++)
      s[4*c+:4] = {mh[c] | md[c] | me[c], me[c], md[c], mh[c]};
    return s;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [NCH-1:0] h, logic [NCH-1:0] d, logic [NCH-1:0] e);
    evt_half = h; evt_done = d; evt_err = e;
    @(negedge clk);
    evt_half = 0; evt_done = 0; evt_err = 0;
    mh |= h; md |= d; me |= e;
  endtask

  task automatic wr(logic sel, logic [W-1:0] data);
    reg_wr = 1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
    if (sel) for (int c = 0; c < NCH; c++) begin
      if (data[4*c] | data[4*c+3]) mh[c] = 0;
      if (data[4*c+1] | data[4*c+3]) md[c] = 0;
      if (data[4*c+2] | data[4*c+3]) me[c] = 0;
    end
  endtask

  task automatic rd(logic sel, output logic [W-1:0] v);
    reg_rd = 1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R9 rdata", reg_rdata, '0);
    chk("R9 irq", W'(irq), '0);
    rd(0, v);
    chk("R9 status", v, '0);
  endtask

  task automatic t_poll();
    logic [W-1:0] v;
    pulse(4'b0000, 4'b0010, 4'b0000);
    rd(0, v);
    chk("R1 polled flag", v, 16'h00A0);
    chk("R2 layout vs model", v, model_status());
    chk("R1 irq stays low when disabled", W'(irq), '0);
    pulse(4'b0100, 4'b0000, 4'b0100);
    rd(0, v);
    chk("R2 ch2 half+err+summary", v, 16'h0DA0);
  endtask

  task automatic t_irq();
    en_done = 4'b0010; #0.1;
    chk("R7 irq on enable", W'(irq), W'(4'b0010));
    en_done = 0; en_err = 4'b0100; #0.1;
    chk("R7 irq follows enable", W'(irq), W'(4'b0100));
    en_err = 0; #0.1;
    chk("R7 irq off when disabled", W'(irq), '0);
    en_half = 4'b0001; #0.1;
    chk("R7 no flag no irq", W'(irq), '0);
    en_half = 0;
  endtask

  task automatic t_clear();
    logic [W-1:0] v;
    en_done = 4'b0010;
    wr(1, 16'h0020);
    chk("R7 irq drops after clear", W'(irq), '0);
    en_done = 0;
    rd(0, v);
    chk("R4 selective clear", v, 16'h0D00);
    chk("R4 model", v, model_status());
    wr(1, 16'h0100);
    rd(0, v);
    chk("R4 err kept", v, 16'h0C00);
  endtask

  task automatic t_global_clr();
    logic [W-1:0] v;
    pulse(4'b1000, 4'b1000, 4'b1000);
    rd(0, v);
    chk("R2 ch3 full", v, 16'hFC00);
    wr(1, 16'h8000);
    rd(0, v);
    chk("R5 summary clear", v, 16'h0C00);
  endtask

  task automatic t_ro();
    logic [W-1:0] v;
    wr(0, 16'hFFFF);
    wr(0, 16'h0000);
    rd(0, v);
    chk("R3 status write ignored", v, 16'h0C00);
  endtask

  task automatic t_race();
    logic [W-1:0] v;
    evt_err = 4'b0100; reg_wr = 1; reg_sel = 1; reg_wdata = 16'h0400;
    @(negedge clk);
    evt_err = 0; reg_wr = 0; reg_wdata = 0;
    rd(0, v);
    chk("R6 set wins over clear", v, 16'h0C00);
    wr(1, 16'hFFFF);
    rd(0, v);
    chk("R4 clear all", v, 16'h0000);
  endtask

  task automatic t_read();
    logic [W-1:0] v;
    pulse(4'b0001, 4'b0000, 4'b0000);
    rd(1, v);
    chk("R8 clear reg reads zero", v, '0);
    rd(0, v);
    chk("R8 status read", v, 16'h0009);
    pulse(4'b0000, 4'b0001, 4'b0000);
    chk("R8 rdata held between reads", reg_rdata, 16'h0009);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_poll();
    t_irq();
    t_clear();
    t_global_clr();
    t_ro();
    t_race();
    t_read();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule